// File: doc/BRIEF.md
# Gated Power-of-Two Clock Divider Bank

This block holds several identical clock divider channels that all run from one reference clock. Each channel produces an output clock at the reference rate divided by a power of two. A three-bit log-encoded factor selects the power: factor f gives a ratio of 2^(f-1), and factors 0 and 1 both give divide-by-one. Software controls every channel through one shared register port. The port takes a single-cycle write strobe and returns read data combinationally. Each channel decodes its own 256-byte window of the address space.

A channel's output starts and stops only in a low phase, so no shortened pulse is ever produced. While a channel is disabled its output is held low. Each write to the enable register starts a settling timer: 2+3·ratio reference cycles for an enable and 3·ratio for a disable. A busy flag stays set until that timer runs out. When busy clears, software knows the transition has finished. The expected sequence for changing the rate is: disable, wait for busy to clear, write the new factor, enable again. A factor written while the channel runs is stored but does not take effect until the next enable.

Top module: `pow2_clkdiv_bank`

## Requirements
- R1: Reset clears every channel: the enable register reads 0x00, the factor register reads 0x00, and every output is low.
- R2: The factor register sits at window offset 0x43, with the factor in bits [2:0]. The enable register sits at offset 0x46. Unused bits read as zero, and every other offset in a window reads 0x00.
- R3: For a factor f from 1 to 7, a running output has a period of 2^(f-1) reference cycles and is high for half of that period. For divide-by-one it follows the reference high phase.
- R4: A factor of 0 produces exactly the same output as a factor of 1 (divide-by-one), and it still reads back as 0.
- R5: Writing 1 to bit 7 of the enable register starts the output. The first rising edge comes no later than 2+3·ratio reference cycles after the write edge.
- R6: Writing 0 to bit 7 stops the output within 3·ratio reference cycles. After that it stays low with no further edges.
- R7: Bit 0 of the enable register is a read-only busy flag. It reads 1 for exactly 2+3·ratio cycles after an enable write and for exactly 3·ratio cycles after a disable write, then reads 0.
- R8: Channel k (numbered from 1) decodes the window at address (k-1)·0x100. A write to one channel changes neither the registers nor the output of any other channel.
- R9: A factor written while the channel is enabled reads back at once, but the running ratio stays the same until the next enable after a disable.
- R10: Starting and stopping happen only in a low phase. The first high pulse after an enable and the last one before a stop are full width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; all logic and all outputs derive from it |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Write strobe for one reference cycle |
| reg_addr | input | clog2(NUM_CH)+8 | Register address: upper bits select the channel window, low 8 bits give the offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| div_clk | output | NUM_CH | Divided clock outputs; bit k-1 belongs to channel k |

## Verification
The bench runs every factor from 0 to 7 through a full enable and disable cycle. It measures the first high pulse and the period against 5·ratio and 10·ratio ns, so a design that mishandled factor 0 or produced a runt first pulse would show a wrong width. The busy flag is sampled one cycle before and one cycle at the end of each settling window, which catches an off-by-one or a window computed from the wrong factor. A factor is rewritten while a channel runs and the period is checked to stay unchanged until the channel is re-enabled, which exposes a design that applies the factor immediately. A second channel is run while its neighbours' edge counters and registers are watched, which exposes a decoder that aliases windows.

// File: rtl/pdv_pkg.sv
package pdv_pkg;

  localparam int FACT_W    = 3;
  localparam int DATA_W    = 8;
  localparam int OFS_W     = 8;
  localparam int EN_BIT    = 7;
  localparam int BUSY_BIT  = 0;
  localparam logic [OFS_W-1:0] OFS_FACT = 8'h43;
  localparam logic [OFS_W-1:0] OFS_CTRL = 8'h46;

  localparam int MAX_FACT  = (1 << FACT_W) - 1;
  localparam int MAX_RATIO = 1 << (MAX_FACT - 1);
  localparam int CNT_W     = $clog2(MAX_RATIO);
  localparam int RAT_W     = CNT_W + 1;
  localparam int MAX_WIN   = 2 + 3 * MAX_RATIO;
  localparam int WIN_W     = $clog2(MAX_WIN + 1);

  typedef logic [FACT_W-1:0] fact_t;
  typedef logic [RAT_W-1:0]  ratio_t;
  typedef logic [WIN_W-1:0]  win_t;

  // log-encoded factor to ratio; 0 and 1 both select divide-by-one
  function automatic ratio_t ratio_of(fact_t f);
    if (f == '0) return ratio_t'(1);
    return ratio_t'(1) << (f - fact_t'(1));
  endfunction

  function automatic win_t win_on(fact_t f);
    return win_t'(2 + 3 * int'(ratio_of(f)));
  endfunction

  function automatic win_t win_off(fact_t f);
    return win_t'(3 * int'(ratio_of(f)));
  endfunction

endpackage

// File: rtl/pdv_regs.sv
module pdv_regs
  import pdv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  output fact_t             fact_o,
  output logic              en_o,
  output logic              ctrl_wr_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic  sel_fact, sel_ctrl;
  logic  fact_we, ctrl_we;
  fact_t fact_q;
  logic  en_q;
  logic  unused_wbits;

  assign sel_fact = (ofs_i == OFS_FACT);
  assign sel_ctrl = (ofs_i == OFS_CTRL);
  assign fact_we  = wr_i && sel_fact;
  assign ctrl_we  = wr_i && sel_ctrl;
  assign unused_wbits = ^wdata_i[EN_BIT-1:FACT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fact_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (fact_we) fact_q <= wdata_i[FACT_W-1:0];
      if (ctrl_we) en_q   <= wdata_i[EN_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_fact) begin
      rdata_o[FACT_W-1:0] = fact_q;
    end else if (sel_ctrl) begin
      rdata_o[EN_BIT]   = en_q;
      rdata_o[BUSY_BIT] = busy_i;
    end
  end

  assign fact_o    = fact_q;
  assign en_o      = en_q;
  assign ctrl_wr_o = ctrl_we;

  AST_CTRL_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (en_o == $past(wdata_i[EN_BIT])))
    else $error("enable bit did not take the written value"); // R5

endmodule

// File: rtl/pdv_settle.sv
module pdv_settle
  import pdv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  win_t win_i,
  output logic busy_o
);

  win_t timer_q, timer_n;

  always_comb begin
    timer_n = timer_q;
    if (load_i)
      timer_n = win_i;
    else if (timer_q != '0)
      timer_n = win_t'(timer_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timer_q <= '0;
    else        timer_q <= timer_n;
  end

  assign busy_o = (timer_q != '0);

  AST_BUSY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && win_i != '0) |=> busy_o)
    else $error("busy not raised by a control write"); // R7

endmodule

// File: rtl/pdv_core.sv
module pdv_core
  import pdv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_i,
  input  fact_t fact_i,
  output logic  run_o,
  output fact_t act_o,
  output logic  clk_o
);

  logic             run_q, run_n;
  logic             run_neg_q;
  logic             phase_q, phase_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] mask_q, mask_n, half_n;
  fact_t            act_q, act_n;
  logic             start, stop, div1;

  always_comb begin
    mask_q = CNT_W'(ratio_of(act_q) - 1'b1);
    start  = en_i && !run_q;
    stop   = !en_i && run_q && ((cnt_q & mask_q) == mask_q);
    run_n  = run_q;
    cnt_n  = cnt_q;
    act_n  = act_q;
    if (start) begin
      run_n = 1'b1;
      cnt_n = '0;
      act_n = fact_i;
    end else if (stop) begin
      run_n = 1'b0;
      cnt_n = '0;
    end else if (run_q) begin
      cnt_n = CNT_W'(cnt_q + 1'b1) & mask_q;
    end
    mask_n  = CNT_W'(ratio_of(act_n) - 1'b1);
    half_n  = CNT_W'(ratio_of(act_n) >> 1);
    phase_n = run_n && (act_n > fact_t'(1)) && ((cnt_n & mask_n) >= half_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      act_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      run_q   <= run_n;
      cnt_q   <= cnt_n;
      act_q   <= act_n;
      phase_q <= phase_n;
    end
  end

  // gate for the divide-by-one path changes only while the reference is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) run_neg_q <= 1'b0;
    else        run_neg_q <= run_q;
  end

  assign div1  = (act_q <= fact_t'(1));
  assign clk_o = div1 ? (clk & run_neg_q) : phase_q;
  assign run_o = run_q;
  assign act_o = act_q;

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> !phase_q)
    else $error("output high at start"); // R10

  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> !phase_q)
    else $error("output high at stop"); // R10

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> $stable(act_q))
    else $error("ratio changed while running"); // R9

endmodule

// File: rtl/pow2_clkdiv_bank.sv
module pow2_clkdiv_bank
  import pdv_pkg::*;
#(
  parameter  int NUM_CH = 4,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + OFS_W
)(
  input  logic              clk_ref,
  input  logic              arst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] div_clk
);

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic [CH_W-1:0]  ch_idx;
  logic [OFS_W-1:0] ofs;

  logic [NUM_CH-1:0] ch_en, ch_busy, ch_run, ch_ctrl_wr, ch_wr;
  fact_t             ch_fact [NUM_CH];
  fact_t             ch_act  [NUM_CH];
  win_t              ch_win  [NUM_CH];
  logic [DATA_W-1:0] ch_rd   [NUM_CH];

  always_ff @(posedge clk_ref or negedge arst_n) begin
    if (!arst_n) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign ch_idx = reg_addr[ADDR_W-1:OFS_W];
  assign ofs    = reg_addr[OFS_W-1:0];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign ch_wr[k]  = reg_wr && (ch_idx == CH_W'(k));
    assign ch_win[k] = reg_wdata[EN_BIT] ? win_on(ch_fact[k]) : win_off(ch_act[k]);

    pdv_regs u_regs (
      .clk       (clk_ref),
      .rst_n     (rst_n),
      .wr_i      (ch_wr[k]),
      .ofs_i     (ofs),
      .wdata_i   (reg_wdata),
      .busy_i    (ch_busy[k]),
      .fact_o    (ch_fact[k]),
      .en_o      (ch_en[k]),
      .ctrl_wr_o (ch_ctrl_wr[k]),
      .rdata_o   (ch_rd[k])
    );

    pdv_settle u_settle (
      .clk    (clk_ref),
      .rst_n  (rst_n),
      .load_i (ch_ctrl_wr[k]),
      .win_i  (ch_win[k]),
      .busy_o (ch_busy[k])
    );

    pdv_core u_core (
      .clk    (clk_ref),
      .rst_n  (rst_n),
      .en_i   (ch_en[k]),
      .fact_i (ch_fact[k]),
      .run_o  (ch_run[k]),
      .act_o  (ch_act[k]),
      .clk_o  (div_clk[k])
    );

    AST_SETTLED_ON: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (ch_en[k] && !ch_busy[k]) |-> ch_run[k])
      else $error("channel not running after enable window"); // R5

    AST_SETTLED_OFF: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (!ch_en[k] && !ch_busy[k]) |-> !ch_run[k])
      else $error("channel still running after disable window"); // R6
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (ch_idx == CH_W'(k)) reg_rdata = ch_rd[k];
    end
  end

endmodule

// File: tb/pow2_clkdiv_bank_test.sv
module pow2_clkdiv_bank_test;

  localparam int NCH = 4;
  localparam int AW  = 10;

  logic          clk_ref = 1'b0;
  logic          arst_n  = 1'b0;
  logic          reg_wr  = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [NCH-1:0] div_clk;

  pow2_clkdiv_bank #(.NUM_CH(NCH)) uut (
    .clk_ref   (clk_ref),
    .arst_n    (arst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .div_clk   (div_clk)
  );

  always #5 clk_ref = ~clk_ref;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // edge bookkeeping per channel
  int  rise_cnt [NCH];
  int  arm_cnt  [NCH];
  time first_rise [NCH];
  for (genvar g = 0; g < NCH; g++) begin : g_mon
    initial begin rise_cnt[g] = 0; arm_cnt[g] = -1; first_rise[g] = 0; end
    always @(posedge div_clk[g]) begin
      if (rise_cnt[g] == arm_cnt[g]) first_rise[g] = $time;
      rise_cnt[g]++;
    end
  end

  // scoreboard
  typedef struct {
    int    kind;   // 0 = register read, 1 = waveform
    int    ch;
    int    exp;
    string tag;
  } item_t;
  item_t q[$];
  int    pend = 0;
  int    mon_ch = 0;
  logic  mon_sig;
  assign mon_sig = div_clk[mon_ch];

  initial begin
    item_t it;
    time t0, t1, t2;
    forever begin
      wait (pend > 0);
      it = q.pop_front();
      if (it.kind == 0) begin
        #1;
        chk(reg_rdata == it.exp[7:0], it.tag, int'(reg_rdata), it.exp);
      end else begin
        mon_ch = it.ch - 1;
        #1;
        @(posedge mon_sig); t0 = $time;
        @(negedge mon_sig); t1 = $time;
        @(posedge mon_sig); t2 = $time;
        chk((t1 - t0) == 5 * it.exp, {it.tag, " high"}, int'(t1 - t0), 5 * it.exp);
        chk((t2 - t0) == 10 * it.exp, {it.tag, " period"}, int'(t2 - t0), 10 * it.exp);
      end
      pend--;
    end
  end

  function automatic logic [AW-1:0] ra(int ch, logic [7:0] o);
    return AW'(((ch - 1) << 8) | int'(o));
  endfunction

  function automatic int ratio(int f);
    return (f == 0) ? 1 : (1 << (f - 1));
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk_ref);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk_ref);
    reg_wr = 1'b0;
  endtask

  task automatic expect_read(input logic [AW-1:0] a, input int exp, input string tag);
    item_t it;
    reg_addr = a;
    it.kind = 0; it.ch = 0; it.exp = exp; it.tag = tag;
    q.push_back(it);
    pend++;
    wait (pend == 0);
  endtask

  task automatic expect_wave(input int ch, input int r, input string tag);
    item_t it;
    it.kind = 1; it.ch = ch; it.exp = r; it.tag = tag;
    q.push_back(it);
    pend++;
  endtask

  // enable with busy and first-edge checks; ratio r is what the channel will run at
  task automatic do_enable(input int ch, input int stored_f, input int r, input string tag);
    int  w;
    time te;
    w = 2 + 3 * ratio(stored_f);
    arm_cnt[ch-1] = rise_cnt[ch-1];
    wr(ra(ch, 8'h46), 8'h80);
    te = $time - 5;
    expect_wave(ch, r, tag);
    repeat (w - 1) @(negedge clk_ref);
    reg_addr = ra(ch, 8'h46); #1;
    chk(reg_rdata == 8'h81, "R7 busy during enable window", int'(reg_rdata), 8'h81);
    @(negedge clk_ref);
    reg_addr = ra(ch, 8'h46); #1;
    chk(reg_rdata == 8'h80, "R7 busy clear after enable window", int'(reg_rdata), 8'h80);
    chk(rise_cnt[ch-1] > arm_cnt[ch-1], "R5 output started", rise_cnt[ch-1], arm_cnt[ch-1] + 1);
    chk((first_rise[ch-1] - te) <= 10 * w, "R5 first edge within window",
        int'(first_rise[ch-1] - te), 10 * w);
    wait (pend == 0);
  endtask

  task automatic do_disable(input int ch, input int r);
    int w, c0;
    w = 3 * r;
    wr(ra(ch, 8'h46), 8'h00);
    repeat (w - 1) @(negedge clk_ref);
    reg_addr = ra(ch, 8'h46); #1;
    chk(reg_rdata == 8'h01, "R7 busy during disable window", int'(reg_rdata), 8'h01);
    @(negedge clk_ref);
    reg_addr = ra(ch, 8'h46); #1;
    chk(reg_rdata == 8'h00, "R7 busy clear after disable window", int'(reg_rdata), 8'h00);
    c0 = rise_cnt[ch-1];
    chk(div_clk[ch-1] == 1'b0, "R6 output low when stopped", int'(div_clk[ch-1]), 0);
    repeat (2 * r + 4) @(negedge clk_ref);
    chk(rise_cnt[ch-1] == c0, "R6 no edges after stop", rise_cnt[ch-1], c0);
    chk(div_clk[ch-1] == 1'b0, "R6 output held low", int'(div_clk[ch-1]), 0);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c1, c2, c4;
    repeat (3) @(negedge clk_ref);
    arst_n = 1'b1;
    repeat (4) @(negedge clk_ref);

    // R1 reset state
    chk(div_clk == '0, "R1 outputs low", int'(div_clk), 0);
    expect_read(ra(1, 8'h43), 0, "R1 factor reset");
    expect_read(ra(1, 8'h46), 0, "R1 enable reset");
    expect_read(ra(4, 8'h46), 0, "R1 enable reset ch4");

    // R2 field placement and unmapped offsets
    wr(ra(2, 8'h43), 8'hFE);
    expect_read(ra(2, 8'h43), 8'h06, "R2 factor bits only");
    expect_read(ra(2, 8'h44), 0, "R2 unmapped offset");
    expect_read(ra(2, 8'h42), 0, "R2 unmapped offset low");
    wr(ra(2, 8'h46), 8'h7F);
    repeat (4) @(negedge clk_ref);
    expect_read(ra(2, 8'h46), 0, "R2 enable reg other bits zero");
    chk(div_clk[1] == 1'b0, "R2 bit7 clear keeps output off", int'(div_clk[1]), 0);

    // R3, R4, R5, R6, R7, R10 over all factors on channel 1
    for (int f = 0; f < 8; f++) begin
      wr(ra(1, 8'h43), 8'(f));
      expect_read(ra(1, 8'h43), f, (f == 0) ? "R4 factor 0 reads back" : "R3 factor reads back");
      do_enable(1, f, ratio(f), (f == 0) ? "R4 factor 0 as divide-by-one" : "R3 R10 ratio");
      do_disable(1, ratio(f));
    end

    // R9 factor write while running
    wr(ra(1, 8'h43), 8'h02);
    do_enable(1, 2, 2, "R9 initial ratio");
    wr(ra(1, 8'h43), 8'h05);
    expect_read(ra(1, 8'h43), 5, "R9 stored factor readback");
    expect_wave(1, 2, "R9 ratio unchanged while running");
    wait (pend == 0);
    do_disable(1, 2);
    do_enable(1, 5, 16, "R9 new ratio after re-enable");
    do_disable(1, 16);

    // R8 channel windows are independent
    c1 = rise_cnt[0]; c2 = rise_cnt[1]; c4 = rise_cnt[3];
    wr(ra(3, 8'h43), 8'h03);
    do_enable(3, 3, 4, "R8 channel 3 ratio");
    expect_read(ra(3, 8'h43), 3, "R8 channel 3 factor");
    expect_read(ra(2, 8'h43), 6, "R8 channel 2 factor untouched");
    expect_read(ra(4, 8'h46), 0, "R8 channel 4 enable untouched");
    expect_read(ra(1, 8'h46), 0, "R8 channel 1 enable untouched");
    chk(rise_cnt[0] == c1, "R8 channel 1 silent", rise_cnt[0], c1);
    chk(rise_cnt[1] == c2, "R8 channel 2 silent", rise_cnt[1], c2);
    chk(rise_cnt[3] == c4, "R8 channel 4 silent", rise_cnt[3], c4);
    do_disable(3, 4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule